// File: doc/BRIEF.md
# Outstanding Request Tag Tracker

This block keeps the set of tags belonging to non-posted requests that a serial-link transaction layer has sent and for which no completion has yet arrived. When the request path asks for a tag, the tracker returns the lowest free tag in the current generation range in the same cycle and marks it in use at the next clock edge. When a completion arrives, its tag is checked against the in-use set and released. A completion that does not match is flagged and otherwise ignored.

The tag field is 10 bits wide. When wide-tag generation is enabled, tags are issued from the 768 values whose two upper bits are not both zero. That combination is held back so that misrouted legacy traffic can be detected. When wide generation is off, only the 256 narrow tags (upper bits zero) are issued. The completion side always accepts any 10-bit tag. An external credit signal gates allocation, so the count of requests in flight never exceeds what the link partner can take.

Top module: `req_tag_tracker`

## Requirements
- R1: A synchronous active-high reset clears every in-use tag. After reset, `outstanding` is 0, `tag_avail` is 1 and `cpl_err` is 0.
- R2: With `wide_gen` high, each grant is the lowest free tag in the range 256..1023, so the upper two bits are never 2'b00. The first grant after reset is 256.
- R3: With `wide_gen` low, each grant is the lowest free tag in the range 0..255. The first grant after reset is 0.
- R4: While `alloc_req` and `credit_ok` are high and a tag is free, `grant_valid` and `grant_tag` are valid in the same cycle. The tag counts as outstanding from the next clock edge, and `outstanding` rises by one.
- R5: While `credit_ok` is low, `grant_valid` stays low, no tag is marked in use and `outstanding` does not change.
- R6: When every tag in the active range is in use (768 wide, 256 narrow), `tag_avail` is low, no grant is given and `outstanding` holds.
- R7: A completion whose tag is outstanding releases it. `outstanding` drops by one at the edge, and the tag is again eligible as the lowest free value.
- R8: A completion whose tag is not outstanding raises `cpl_err` for exactly the one cycle after the completion's edge, and leaves `outstanding` and the in-use set unchanged.
- R9: With `wide_gen` high, a completion whose upper two tag bits are 2'b00 is reserved. It raises `cpl_err` and releases nothing, even if that narrow tag was issued earlier in narrow mode.
- R10: A wide tag (256..1023) that was issued in wide mode is retired without error after `wide_gen` has been switched low, because the receive side always accepts 10-bit tags.
- R11: An allocation and a valid completion in the same cycle both take effect, and `outstanding` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_gen | input | 1 | 1: issue 10-bit tags 256..1023; 0: issue tags 0..255 |
| credit_ok | input | 1 | Header credit available; allocation stalls when low |
| alloc_req | input | 1 | Request a tag this cycle |
| cpl_valid | input | 1 | A completion arrives this cycle |
| cpl_tag | input | 10 | Tag carried by the completion |
| grant_valid | output | 1 | A tag is granted this cycle |
| grant_tag | output | 10 | Granted tag |
| tag_avail | output | 1 | At least one tag is free in the active range |
| outstanding | output | 11 | Number of tags currently in use |
| cpl_err | output | 1 | One-cycle pulse for an unmatched or reserved completion |

## Verification
Allocation is driven from an empty map in both widths, so the lowest-index search can be told apart from a search that ignores the window. A full fill of each range separates a correct limit of 768 or 256 from an off-by-one or a search that leaks into the reserved range. Completions are sent for a matched tag, an unmatched tag, a narrow tag after a switch to wide mode, and a wide tag after a switch to narrow mode. These four cases separate release, unknown-tag error, reserved-tag error and mode-independent acceptance. One cycle holds both an allocate and a release, and one stall holds credit low, so a wrong count update and a missing credit gate each show at the ports.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;

    localparam int unsigned TAG_W_DEF    = 10;
    localparam int unsigned LEGACY_W_DEF = 8;

    typedef enum logic [1:0] {
        CPL_IDLE     = 2'd0,
        CPL_RETIRE   = 2'd1,
        CPL_UNKNOWN  = 2'd2,
        CPL_RESERVED = 2'd3
    } cpl_verdict_e;

    // Narrow indices (below legacy_num) are the reserved upper-bit combination in wide mode.
    function automatic logic in_gen_window(int unsigned idx, logic wide, int unsigned legacy_num);
        return wide ? (idx >= legacy_num) : (idx < legacy_num);
    endfunction

    function automatic logic is_error(cpl_verdict_e v);
        return (v == CPL_UNKNOWN) || (v == CPL_RESERVED);
    endfunction

endpackage

// File: rtl/tagtrk_find_free.sv
module tagtrk_find_free
    import tagtrk_pkg::*;
#(
    parameter int unsigned NUM        = 1024,
    parameter int unsigned LEGACY_NUM = 256,
    parameter int unsigned IDX_W      = 10
) (
    input  logic [NUM-1:0]   in_use,
    input  logic             wide,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [NUM-1:0] eligible;

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_elig
            assign eligible[g] = !in_use[g] && in_gen_window(g, wide, LEGACY_NUM);
        end
    endgenerate

    // Scan from the top so the last hit is the lowest eligible index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tagtrk_cpl_check.sv
module tagtrk_cpl_check
    import tagtrk_pkg::*;
#(
    parameter int unsigned NUM        = 1024,
    parameter int unsigned LEGACY_NUM = 256,
    parameter int unsigned IDX_W      = 10
) (
    input  logic             cpl_valid,
    input  logic [IDX_W-1:0] cpl_tag,
    input  logic             wide,
    input  logic [NUM-1:0]   in_use,
    output cpl_verdict_e     verdict
);

    logic reserved_hit;

    assign reserved_hit = wide && (32'(cpl_tag) < LEGACY_NUM);

    always_comb begin
        if (!cpl_valid)            verdict = CPL_IDLE;
        else if (reserved_hit)     verdict = CPL_RESERVED;
        else if (!in_use[cpl_tag]) verdict = CPL_UNKNOWN;
        else                       verdict = CPL_RETIRE;
    end

endmodule

// File: rtl/tagtrk_valid_map.sv
module tagtrk_valid_map #(
    parameter int unsigned NUM   = 1024,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NUM-1:0]   in_use,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_use <= '0;
            count  <= '0;
        end else begin
            if (set_en) in_use[set_idx] <= 1'b1;
            if (clr_en) in_use[clr_idx] <= 1'b0;
            case ({set_en, clr_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: a granted tag is never one already in use
    assert_set_is_free_R4: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !in_use[set_idx]);

    // R7: a release only touches a tag that is in use
    assert_clr_is_used_R7: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> in_use[clr_idx]);

    // R6: the count never exceeds the tag space
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= NUM);

endmodule

// File: rtl/req_tag_tracker.sv
module req_tag_tracker
    import tagtrk_pkg::*;
#(
    parameter int unsigned TAG_W    = TAG_W_DEF,
    parameter int unsigned LEGACY_W = LEGACY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wide_gen,
    input  logic             credit_ok,
    input  logic             alloc_req,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    output logic             grant_valid,
    output logic [TAG_W-1:0] grant_tag,
    output logic             tag_avail,
    output logic [TAG_W:0]   outstanding,
    output logic             cpl_err
);

    localparam int unsigned NUM        = 1 << TAG_W;
    localparam int unsigned LEGACY_NUM = 1 << LEGACY_W;
    localparam int unsigned CNT_W      = TAG_W + 1;

    logic [NUM-1:0]   in_use;
    logic             free_found;
    logic [TAG_W-1:0] free_idx;
    cpl_verdict_e     verdict;
    logic             retire_en;

    tagtrk_find_free #(.NUM(NUM), .LEGACY_NUM(LEGACY_NUM), .IDX_W(TAG_W)) u_find (
        .in_use (in_use),
        .wide   (wide_gen),
        .found  (free_found),
        .idx    (free_idx)
    );

    tagtrk_cpl_check #(.NUM(NUM), .LEGACY_NUM(LEGACY_NUM), .IDX_W(TAG_W)) u_check (
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .wide      (wide_gen),
        .in_use    (in_use),
        .verdict   (verdict)
    );

    assign grant_valid = alloc_req && credit_ok && free_found;
    assign grant_tag   = free_idx;
    assign tag_avail   = free_found;
    assign retire_en   = (verdict == CPL_RETIRE);

    tagtrk_valid_map #(.NUM(NUM), .IDX_W(TAG_W), .CNT_W(CNT_W)) u_map (
        .clk     (clk),
        .rst     (rst),
        .set_en  (grant_valid),
        .set_idx (free_idx),
        .clr_en  (retire_en),
        .clr_idx (cpl_tag),
        .in_use  (in_use),
        .count   (outstanding)
    );

    always_ff @(posedge clk) begin
        if (rst) cpl_err <= 1'b0;
        else     cpl_err <= is_error(verdict);
    end

    // R5: no grant without credit
    assert_no_grant_without_credit_R5: assert property (@(posedge clk) disable iff (rst)
        !credit_ok |-> !grant_valid);

    // R2: wide grants avoid the reserved upper-bit combination
    assert_wide_window_R2: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && wide_gen) |-> (32'(grant_tag) >= LEGACY_NUM));

    // R3: narrow grants stay below the legacy limit
    assert_narrow_window_R3: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !wide_gen) |-> (32'(grant_tag) < LEGACY_NUM));

    // R8: a rejected completion pulses the error and leaves the count alone
    assert_reject_no_change_R8: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !retire_en && !grant_valid) |=> (cpl_err && $stable(outstanding)));

    // R11: grant plus release in one cycle keeps the count
    assert_swap_keeps_count_R11: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && retire_en) |=> $stable(outstanding));

endmodule

// File: tb/test_req_tag_tracker.sv
module test_req_tag_tracker;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wide_gen;
    logic       credit_ok;
    logic       alloc_req;
    logic       cpl_valid;
    logic [9:0] cpl_tag;
    logic       grant_valid;
    logic [9:0] grant_tag;
    logic       tag_avail;
    logic [10:0] outstanding;
    logic       cpl_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    req_tag_tracker i_req_tag_tracker (
        .clk(clk), .rst(rst), .wide_gen(wide_gen), .credit_ok(credit_ok),
        .alloc_req(alloc_req), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .grant_valid(grant_valid), .grant_tag(grant_tag), .tag_avail(tag_avail),
        .outstanding(outstanding), .cpl_err(cpl_err)
    );

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Inputs change at posedge+1; combinational outputs are read at negedge.
    task automatic do_reset(logic wide);
        rst = 1'b1; alloc_req = 1'b0; cpl_valid = 1'b0; cpl_tag = '0;
        credit_ok = 1'b1; wide_gen = wide;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic alloc_expect(string req, int exp_tag);
        alloc_req = 1'b1;
        @(negedge clk);
        check({req, " grant_valid"}, int'(grant_valid), 1);
        check({req, " grant_tag"}, int'(grant_tag), exp_tag);
        @(posedge clk); #1;
        alloc_req = 1'b0;
    endtask

    task automatic send_cpl(string req, int tag, int exp_err);
        cpl_valid = 1'b1; cpl_tag = 10'(tag);
        @(posedge clk); #1;
        cpl_valid = 1'b0;
        @(negedge clk);
        check({req, " cpl_err"}, int'(cpl_err), exp_err);
        @(posedge clk); #1;
        check({req, " cpl_err clears"}, int'(cpl_err), 0);
    endtask

    task automatic t_reset_state;
        do_reset(1'b1);
        @(negedge clk);
        check("R1 outstanding", int'(outstanding), 0);
        check("R1 tag_avail", int'(tag_avail), 1);
        check("R1 cpl_err", int'(cpl_err), 0);
        check("R1 grant_valid idle", int'(grant_valid), 0);
        @(posedge clk); #1;
    endtask

    task automatic t_wide_alloc;
        do_reset(1'b1);
        alloc_expect("R2 first", 256);
        alloc_expect("R2 second", 257);
        alloc_expect("R4 third", 258);
        check("R4 outstanding", int'(outstanding), 3);
    endtask

    task automatic t_narrow_alloc;
        do_reset(1'b0);
        alloc_expect("R3 first", 0);
        alloc_expect("R3 second", 1);
        check("R3 outstanding", int'(outstanding), 2);
    endtask

    task automatic t_credit_stall;
        do_reset(1'b1);
        credit_ok = 1'b0; alloc_req = 1'b1;
        @(negedge clk);
        check("R5 grant_valid", int'(grant_valid), 0);
        @(posedge clk); #1;
        alloc_req = 1'b0; credit_ok = 1'b1;
        check("R5 outstanding", int'(outstanding), 0);
        alloc_expect("R5 after stall", 256);
    endtask

    task automatic t_retire_and_errors;
        do_reset(1'b1);
        alloc_expect("R7 setup", 256);
        alloc_expect("R7 setup", 257);
        alloc_expect("R7 setup", 258);
        send_cpl("R7 retire", 257, 0);
        check("R7 outstanding", int'(outstanding), 2);
        alloc_expect("R7 reuse", 257);
        send_cpl("R8 unknown", 300, 1);
        check("R8 outstanding", int'(outstanding), 3);
        alloc_expect("R8 map intact", 259);
    endtask

    task automatic t_reserved;
        do_reset(1'b0);
        alloc_expect("R9 setup", 0);
        wide_gen = 1'b1;
        send_cpl("R9 reserved", 0, 1);
        check("R9 outstanding", int'(outstanding), 1);
        wide_gen = 1'b0;
        alloc_expect("R9 tag 0 still used", 1);
    endtask

    task automatic t_cross_mode;
        do_reset(1'b1);
        alloc_expect("R10 setup", 256);
        wide_gen = 1'b0;
        send_cpl("R10 wide after narrow", 256, 0);
        check("R10 outstanding", int'(outstanding), 0);
    endtask

    task automatic t_same_cycle;
        do_reset(1'b1);
        alloc_expect("R11 setup", 256);
        alloc_expect("R11 setup", 257);
        alloc_req = 1'b1; cpl_valid = 1'b1; cpl_tag = 10'd256;
        @(negedge clk);
        check("R11 grant_tag", int'(grant_tag), 258);
        @(posedge clk); #1;
        alloc_req = 1'b0; cpl_valid = 1'b0;
        check("R11 outstanding", int'(outstanding), 2);
        check("R11 cpl_err", int'(cpl_err), 0);
        alloc_expect("R11 released tag reused", 256);
    endtask

    task automatic t_fill(logic wide);
        int base = wide ? 256 : 0;
        int cnt  = wide ? 768 : 256;
        do_reset(wide);
        for (int k = 0; k < cnt; k++) alloc_expect("R6 fill", base + k);
        alloc_req = 1'b1;
        @(negedge clk);
        check("R6 tag_avail", int'(tag_avail), 0);
        check("R6 grant_valid", int'(grant_valid), 0);
        @(posedge clk); #1;
        alloc_req = 1'b0;
        check("R6 outstanding", int'(outstanding), cnt);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_wide_alloc();
        t_narrow_alloc();
        t_credit_stall();
        t_retire_and_errors();
        t_reserved();
        t_cross_mode();
        t_same_cycle();
        t_fill(1'b1);
        t_fill(1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule